// File: doc/BRIEF.md
# Transceiver PHY Reset Sequencer

This block drives the four reset lines of one serial transceiver channel: transmit analog, transmit digital, receive analog and receive digital. It runs on a single free-running clock whose frequency is a parameter. Every hold time is given in nanoseconds and is turned into clock cycles at elaboration. A master reset input and three status inputs are each brought into the clock domain through a two-flop synchronizer. The status inputs are the transmit PLL lock, a PLL calibration-busy flag and the receiver's lock-to-data flag.

A reset line releases only after its own gating conditions have been clear for its full hold time. The PLL lock flag passes through a hysteresis filter before it can release the transmit digital reset, so short lock pulses are ignored. Each digital reset has its own recovery mode. In automatic mode, a loss of its lock source re-arms the reset. In manual mode, the reset is left alone once it has released. An ordering option makes the receive digital reset wait for the transmit digital reset. A fast-simulation option shortens every hold count.

Top module: `phyRstSeq`

## Requirements
- R1: While the master reset is high, all four reset outputs are high and both ready outputs are low. The master reset is asserted asynchronously and released through two synchronizer flops.
- R2: A hold time of T ns becomes N = ceil(T*CLK_MHZ/1000) cycles (minimum 1). After the master reset input falls, the transmit analog reset falls N_ta clock edges after the second synchronizer edge.
- R3: When USE_CAL_BUSY is 1, a high calibration-busy input asserts the transmit analog reset, and through it the transmit digital reset. The analog reset falls N_ta edges after the synchronized flag clears. When USE_CAL_BUSY is 0, the flag has no effect on any output.
- R4: The filtered lock rises only after H+1 consecutive high samples of the synchronized lock, where H is the hysteresis time in cycles (0 means no filtering). It falls on the first low sample.
- R5: The transmit digital reset falls N_td edges after the last edge at which the transmit analog reset was high or the filtered lock was low.
- R6: With TX_AUTO=1, a loss of filtered lock re-asserts the transmit digital reset. With TX_AUTO=0, a loss of lock after release leaves it low.
- R7: The receive analog reset falls N_ra edges after the synchronized master reset clears. The default receive analog hold is 40 ns and the default receive digital hold is 5000 ns.
- R8: The receive digital reset falls N_rd edges after the last edge at which the receive analog reset was high or the synchronized lock-to-data flag was low.
- R9: With RX_AUTO=1, a loss of lock-to-data re-asserts the receive digital reset. With RX_AUTO=0, it leaves the released reset low.
- R10: With TX_BEFORE_RX=1, the receive digital reset is also held while the transmit digital reset is high, so it always releases later.
- R11: txReady is high exactly when both transmit resets are low, and rxReady is high exactly when both receive resets are low. Each drops in the same cycle that either of its resets rises.
- R12: With FAST_SIM=1, every cycle count is divided by 64 and rounded up, with a minimum of 1. A zero hysteresis stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstIn | input | 1 | Master reset, active high, asynchronous |
| pllLocked | input | 1 | Transmit PLL lock status |
| calBusy | input | 1 | PLL calibration in progress |
| cdrLocked | input | 1 | Receiver locked to incoming data |
| txAnaRst | output | 1 | Transmit analog reset, active high |
| txDigRst | output | 1 | Transmit digital reset, active high |
| rxAnaRst | output | 1 | Receive analog reset, active high |
| rxDigRst | output | 1 | Receive digital reset, active high |
| txReady | output | 1 | Transmit path out of reset |
| rxReady | output | 1 | Receive path out of reset |

## Verification
Three instances share the stimulus. One uses automatic recovery with ordering, one uses manual recovery with calibration-busy disabled, and one uses fast-simulation counts. The release from the master reset pins every fall edge to an exact cycle, and the ordered and unordered receive releases land on different cycles. A one-cycle lock drop, a train of lock pulses one sample too short for the filter, a lock-to-data loss and a busy pulse each split automatic from manual behaviour. The re-assertion and re-release cycles and the number of falls confirm that glitches are rejected.

// File: rtl/phyRstPkg.sv
package phyRstPkg;

  typedef struct packed {
    logic txAnaHold;
    logic txDigHold;
    logic rxAnaHold;
    logic rxDigHold;
  } holdReq_t;

  typedef struct packed {
    logic txAna;
    logic txDig;
    logic rxAna;
    logic rxDig;
  } rstState_t;

  // Nanoseconds to clock cycles, rounded up; optional fast-sim shrink.
  function automatic int unsigned nsToCycles(input int unsigned ns,
                                             input int unsigned mhz,
                                             input bit fast,
                                             input bit allowZero);
    longint unsigned c;
    c = (longint'(ns) * longint'(mhz) + 64'd999) / 64'd1000;
    if (fast) c = (c + 64'd63) / 64'd64;
    if (!allowZero && c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/phyRstSync.sv
module phyRstSync #(
  parameter int unsigned W = 1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= {W{RST_VAL}};
      stage2 <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/phyRstHold.sv
module phyRstHold #(
  parameter int unsigned N = 1
) (
  input  logic clk,
  input  logic arst,
  input  logic hold,
  output logic rstOut
);
  localparam int unsigned CW = (N < 2) ? 1 : $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      rstOut <= 1'b1;
      cnt    <= '0;
    end else if (hold) begin
      rstOut <= 1'b1;
      cnt    <= '0;
    end else if (rstOut) begin
      if (cnt == LAST) rstOut <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

  // R2: a reset only falls on an edge where its gate was clear
  assert_hold_release_R2: assert property (@(posedge clk) disable iff (arst)
    $fell(rstOut) |-> $past(!hold));
endmodule

// File: rtl/phyRstDp.sv
module phyRstDp import phyRstPkg::*; #(
  parameter int unsigned TX_ANA_CYC = 1,
  parameter int unsigned TX_DIG_CYC = 1,
  parameter int unsigned RX_ANA_CYC = 1,
  parameter int unsigned RX_DIG_CYC = 1,
  parameter int unsigned HYST_CYC   = 0
) (
  input  logic       clk,
  input  logic       rstS,
  input  logic       lockS,
  input  holdReq_t   req,
  output logic       lockF,
  output rstState_t  rsts
);
  localparam int unsigned CYC [4] = '{TX_ANA_CYC, TX_DIG_CYC, RX_ANA_CYC, RX_DIG_CYC};

  logic [3:0] holdV;
  logic [3:0] outV;

  assign holdV = {req.rxDigHold, req.rxAnaHold, req.txDigHold, req.txAnaHold};

  for (genvar g = 0; g < 4; g++) begin : gHold
    phyRstHold #(.N(CYC[g])) uHold (
      .clk   (clk),
      .arst  (rstS),
      .hold  (holdV[g]),
      .rstOut(outV[g])
    );
  end

  assign rsts.txAna = outV[0];
  assign rsts.txDig = outV[1];
  assign rsts.rxAna = outV[2];
  assign rsts.rxDig = outV[3];

  // Lock hysteresis: H+1 consecutive high samples, drop on first low.
  if (HYST_CYC == 0) begin : gNoHyst
    always_ff @(posedge clk or posedge rstS) begin
      if (rstS) lockF <= 1'b0;
      else      lockF <= lockS;
    end
  end else begin : gHyst
    localparam int unsigned HW = $clog2(HYST_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(HYST_CYC);
    logic [HW-1:0] hCnt;
    always_ff @(posedge clk or posedge rstS) begin
      if (rstS) begin
        hCnt  <= '0;
        lockF <= 1'b0;
      end else if (!lockS) begin
        hCnt  <= '0;
        lockF <= 1'b0;
      end else if (hCnt == HMAX) begin
        lockF <= 1'b1;
      end else begin
        hCnt  <= hCnt + 1'b1;
      end
    end
  end

  // R4: filtered lock only rises after a high raw sample
  assert_lock_filter_R4: assert property (@(posedge clk) disable iff (rstS)
    $rose(lockF) |-> $past(lockS));
endmodule

// File: rtl/phyRstCtrl.sv
module phyRstCtrl import phyRstPkg::*; #(
  parameter bit TX_AUTO      = 1'b1,
  parameter bit RX_AUTO      = 1'b1,
  parameter bit TX_BEFORE_RX = 1'b0,
  parameter bit USE_CAL_BUSY = 1'b1
) (
  input  logic      clk,
  input  logic      rstS,
  input  logic      lockF,
  input  logic      busyS,
  input  logic      cdrS,
  input  rstState_t rsts,
  output holdReq_t  req,
  output logic      txReady,
  output logic      rxReady
);
  logic busyGate;
  logic txLockGate;
  logic rxLockGate;
  logic orderGate;

  assign busyGate   = USE_CAL_BUSY & busyS;
  assign txLockGate = !lockF & (TX_AUTO | rsts.txDig);
  assign rxLockGate = !cdrS  & (RX_AUTO | rsts.rxDig);
  assign orderGate  = TX_BEFORE_RX & rsts.txDig;

  always_comb begin
    req.txAnaHold = rstS | busyGate;
    req.txDigHold = rstS | rsts.txAna | txLockGate;
    req.rxAnaHold = rstS;
    req.rxDigHold = rstS | rsts.rxAna | rxLockGate | orderGate;
  end

  assign txReady = !rsts.txAna & !rsts.txDig;
  assign rxReady = !rsts.rxAna & !rsts.rxDig;

  // R5: TX digital release needs analog released and filtered lock
  assert_txdig_gated_R5: assert property (@(posedge clk) disable iff (rstS)
    $fell(rsts.txDig) |-> $past(!rsts.txAna && lockF));

  // R8: RX digital release needs analog released and data lock
  assert_rxdig_gated_R8: assert property (@(posedge clk) disable iff (rstS)
    $fell(rsts.rxDig) |-> $past(!rsts.rxAna && cdrS));

  if (TX_BEFORE_RX) begin : gOrderChk
    // R10: RX digital never releases while TX digital is held
    assert_rx_after_tx_R10: assert property (@(posedge clk) disable iff (rstS)
      $fell(rsts.rxDig) |-> $past(!rsts.txDig));
  end

  if (!TX_AUTO) begin : gTxManChk
    // R6: manual mode, lock loss cannot re-arm TX digital
    assert_tx_manual_R6: assert property (@(posedge clk) disable iff (rstS)
      (!rsts.txDig && !rsts.txAna) |=> !rsts.txDig);
  end

  if (!RX_AUTO) begin : gRxManChk
    // R9: manual mode, data-lock loss cannot re-arm RX digital
    assert_rx_manual_R9: assert property (@(posedge clk) disable iff (rstS)
      (!rsts.rxDig && !rsts.rxAna && !(TX_BEFORE_RX && rsts.txDig)) |=> !rsts.rxDig);
  end

  if (!USE_CAL_BUSY) begin : gBusyChk
    // R3: busy disabled, TX analog stays released
    assert_busy_ignored_R3: assert property (@(posedge clk) disable iff (rstS)
      !rsts.txAna |=> !rsts.txAna);
  end
endmodule

// File: rtl/phyRstSeq.sv
module phyRstSeq import phyRstPkg::*; #(
  parameter int unsigned CLK_MHZ      = 250,
  parameter int unsigned TX_ANA_NS    = 70,
  parameter int unsigned TX_DIG_NS    = 70,
  parameter int unsigned RX_ANA_NS    = 40,
  parameter int unsigned RX_DIG_NS    = 5000,
  parameter int unsigned LOCK_HYST_NS = 1000,
  parameter bit          TX_AUTO      = 1'b1,
  parameter bit          RX_AUTO      = 1'b1,
  parameter bit          TX_BEFORE_RX = 1'b0,
  parameter bit          USE_CAL_BUSY = 1'b1,
  parameter bit          FAST_SIM     = 1'b0
) (
  input  logic clk,
  input  logic rstIn,
  input  logic pllLocked,
  input  logic calBusy,
  input  logic cdrLocked,
  output logic txAnaRst,
  output logic txDigRst,
  output logic rxAnaRst,
  output logic rxDigRst,
  output logic txReady,
  output logic rxReady
);
  localparam int unsigned TX_ANA_CYC = nsToCycles(TX_ANA_NS, CLK_MHZ, FAST_SIM, 1'b0);
  localparam int unsigned TX_DIG_CYC = nsToCycles(TX_DIG_NS, CLK_MHZ, FAST_SIM, 1'b0);
  localparam int unsigned RX_ANA_CYC = nsToCycles(RX_ANA_NS, CLK_MHZ, FAST_SIM, 1'b0);
  localparam int unsigned RX_DIG_CYC = nsToCycles(RX_DIG_NS, CLK_MHZ, FAST_SIM, 1'b0);
  localparam int unsigned HYST_CYC   = nsToCycles(LOCK_HYST_NS, CLK_MHZ, FAST_SIM, 1'b1);

  logic       rstS;
  logic [2:0] statS;
  logic       lockF;
  holdReq_t   req;
  rstState_t  rsts;

  phyRstSync #(.W(1), .RST_VAL(1'b1)) uRstSync (
    .clk (clk),
    .arst(rstIn),
    .d   (1'b0),
    .q   (rstS)
  );

  phyRstSync #(.W(3), .RST_VAL(1'b0)) uStatSync (
    .clk (clk),
    .arst(1'b0),
    .d   ({cdrLocked, calBusy, pllLocked}),
    .q   (statS)
  );

  phyRstDp #(
    .TX_ANA_CYC(TX_ANA_CYC),
    .TX_DIG_CYC(TX_DIG_CYC),
    .RX_ANA_CYC(RX_ANA_CYC),
    .RX_DIG_CYC(RX_DIG_CYC),
    .HYST_CYC  (HYST_CYC)
  ) uDp (
    .clk  (clk),
    .rstS (rstS),
    .lockS(statS[0]),
    .req  (req),
    .lockF(lockF),
    .rsts (rsts)
  );

  phyRstCtrl #(
    .TX_AUTO     (TX_AUTO),
    .RX_AUTO     (RX_AUTO),
    .TX_BEFORE_RX(TX_BEFORE_RX),
    .USE_CAL_BUSY(USE_CAL_BUSY)
  ) uCtrl (
    .clk    (clk),
    .rstS   (rstS),
    .lockF  (lockF),
    .busyS  (statS[1]),
    .cdrS   (statS[2]),
    .rsts   (rsts),
    .req    (req),
    .txReady(txReady),
    .rxReady(rxReady)
  );

  assign txAnaRst = rsts.txAna;
  assign txDigRst = rsts.txDig;
  assign rxAnaRst = rsts.rxAna;
  assign rxDigRst = rsts.rxDig;
endmodule

// File: tb/sim_phyRstSeq.sv
`timescale 1ns/1ps
module sim_phyRstSeq;
  localparam int MHZ = 250;

  logic clk = 1'b0;
  logic rstIn = 1'b1, pllLocked = 1'b1, calBusy = 1'b0, cdrLocked = 1'b1;
  logic [11:0] obs;
  logic [5:0]  rdy;
  int cyc = 0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;
  int fallAt [12], riseAt [12], fallCnt [12], riseCnt [12];
  logic [11:0] prevObs = '1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phyRstSeq #(.CLK_MHZ(MHZ), .TX_ANA_NS(20), .TX_DIG_NS(30), .RX_ANA_NS(40),
              .RX_DIG_NS(50), .LOCK_HYST_NS(24), .TX_AUTO(1'b1), .RX_AUTO(1'b1),
              .TX_BEFORE_RX(1'b1), .USE_CAL_BUSY(1'b1), .FAST_SIM(1'b0)) u0 (
    .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .calBusy(calBusy), .cdrLocked(cdrLocked),
    .txAnaRst(obs[0]), .txDigRst(obs[1]), .rxAnaRst(obs[2]), .rxDigRst(obs[3]),
    .txReady(rdy[0]), .rxReady(rdy[1]));

  phyRstSeq #(.CLK_MHZ(MHZ), .TX_ANA_NS(20), .TX_DIG_NS(30), .RX_ANA_NS(40),
              .RX_DIG_NS(50), .LOCK_HYST_NS(24), .TX_AUTO(1'b0), .RX_AUTO(1'b0),
              .TX_BEFORE_RX(1'b0), .USE_CAL_BUSY(1'b0), .FAST_SIM(1'b0)) u1 (
    .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .calBusy(calBusy), .cdrLocked(cdrLocked),
    .txAnaRst(obs[4]), .txDigRst(obs[5]), .rxAnaRst(obs[6]), .rxDigRst(obs[7]),
    .txReady(rdy[2]), .rxReady(rdy[3]));

  phyRstSeq #(.CLK_MHZ(MHZ), .TX_BEFORE_RX(1'b0), .FAST_SIM(1'b1)) u2 (
    .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .calBusy(calBusy), .cdrLocked(cdrLocked),
    .txAnaRst(obs[8]), .txDigRst(obs[9]), .rxAnaRst(obs[10]), .rxDigRst(obs[11]),
    .txReady(rdy[4]), .rxReady(rdy[5]));

  function automatic int cycOf(int ns, bit fast);
    int c = (ns * MHZ + 999) / 1000;
    if (fast) c = (c + 63) / 64;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Edge recorder: times are the index of the clock edge that changed the output
  initial for (int i = 0; i < 12; i++) begin
    fallAt[i] = -1; riseAt[i] = -1; fallCnt[i] = 0; riseCnt[i] = 0;
  end
  always @(negedge clk) begin
    for (int i = 0; i < 12; i++) begin
      if (prevObs[i] && !obs[i]) begin fallAt[i] = cyc; fallCnt[i]++; end
      if (!prevObs[i] && obs[i]) begin riseAt[i] = cyc; riseCnt[i]++; end
    end
    prevObs = obs;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  int nTa, nTd, nRa, nRd, hC, r, k, f, base0, base1, txdFall;

  initial begin
    nTa = cycOf(20, 0); nTd = cycOf(30, 0); nRa = cycOf(40, 0); nRd = cycOf(50, 0);
    hC = (24 * MHZ + 999) / 1000;

    waitCyc(5);
    // R1: reset state
    chk("R1", "resets high during reset", int'(obs), 12'hFFF);
    chk("R1", "ready low during reset", int'(rdy), 0);

    // Release master reset
    r = cyc; rstIn = 1'b0;
    waitCyc(60);
    chk("R2", "u0 txAna fall", fallAt[0], r + 2 + nTa);
    chk("R2", "u1 txAna fall", fallAt[4], r + 2 + nTa);
    txdFall = max2(r + 2 + nTa, r + 3 + hC) + nTd;
    chk("R5", "u0 txDig fall", fallAt[1], txdFall);
    chk("R5", "u1 txDig fall", fallAt[5], txdFall);
    chk("R7", "u0 rxAna fall", fallAt[2], r + 2 + nRa);
    chk("R10", "u0 ordered rxDig fall", fallAt[3], max2(r + 2 + nRa, txdFall) + nRd);
    chk("R8", "u1 unordered rxDig fall", fallAt[7], r + 2 + nRa + nRd);
    chk("R12", "u2 fast rxDig fall", fallAt[11], r + 2 + cycOf(40, 1) + cycOf(5000, 1));
    chk("R7", "u2 fast rxAna fall", fallAt[10], r + 2 + cycOf(40, 1));
    chk("R11", "readies after release", int'(rdy[3:0]), 4'hF);

    // One-cycle lock drop
    k = cyc; pllLocked = 1'b0;
    waitCyc(1); pllLocked = 1'b1;
    waitCyc(4);
    chk("R11", "u0 txReady drops", int'(rdy[0]), 0);
    chk("R11", "u1 txReady stays", int'(rdy[2]), 1);
    waitCyc(40);
    chk("R6", "u0 txDig re-assert", riseAt[1], k + 4);
    chk("R6", "u0 txDig re-release", fallAt[1], k + 4 + hC + nTd);
    chk("R10", "u0 rxDig follows txDig", riseAt[3], k + 5);
    chk("R10", "u0 rxDig re-release", fallAt[3], k + 4 + hC + nTd + nRd);
    chk("R6", "u1 manual txDig no rise", riseCnt[5], 0);

    // Lock pulses one sample too short for the filter
    base0 = fallCnt[1];
    k = cyc; pllLocked = 1'b0; waitCyc(4);
    pllLocked = 1'b1; waitCyc(5);
    pllLocked = 1'b0; waitCyc(3);
    pllLocked = 1'b1; waitCyc(hC);
    pllLocked = 1'b0; waitCyc(3);
    f = cyc; pllLocked = 1'b1;
    waitCyc(40);
    chk("R4", "u0 txDig single fall", fallCnt[1] - base0, 1);
    chk("R4", "u0 txDig fall after stable lock", fallAt[1], f + 3 + hC + nTd);
    chk("R4", "u0 txDig rise", riseAt[1], k + 4);
    chk("R6", "u1 manual txDig still released", int'(obs[5]), 0);

    // Lock-to-data loss
    base1 = riseCnt[7];
    k = cyc; cdrLocked = 1'b0; waitCyc(10);
    cdrLocked = 1'b1;
    waitCyc(40);
    chk("R9", "u0 rxDig re-assert", riseAt[3], k + 3);
    chk("R9", "u0 rxDig re-release", fallAt[3], k + 12 + nRd);
    chk("R9", "u1 manual rxDig no rise", riseCnt[7] - base1, 0);
    chk("R8", "u0 rxAna untouched", int'(obs[2]), 0);

    // Calibration busy pulse
    base1 = riseCnt[4];
    k = cyc; calBusy = 1'b1; waitCyc(6);
    calBusy = 1'b0;
    waitCyc(4);
    chk("R3", "u1 txReady with busy disabled", int'(rdy[2]), 1);
    waitCyc(56);
    chk("R3", "u0 txAna rise", riseAt[0], k + 3);
    chk("R3", "u0 txAna fall", fallAt[0], k + 8 + nTa);
    chk("R5", "u0 txDig fall after busy", fallAt[1], k + 8 + nTa + nTd);
    chk("R3", "u1 txAna no rise", riseCnt[4] - base1, 0);
    chk("R11", "u0 readies restored", int'(rdy[1:0]), 2'b11);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule